// File: doc/BRIEF.md
# Per-Bank Open-Row Tracker

This block keeps a record of which DRAM row is currently open in every internal bank behind each of two chip selects. There are four banks per chip select, so eight records. Each record holds a valid flag and a 14-bit row tag. When the memory controller receives a CPU read or write, it presents the chip select, bank and row of that access. One cycle later, the tracker reports which command sequence must come first. A row hit means the access goes straight ahead. A row conflict means the bank is closed and then the new row is opened. A bank idle result means the row only has to be opened.

The controller also reports every activate, precharge and refresh command it issues, and the tracker updates its records from these reports. Both chip selects share one configuration, which gives the number of meaningful row bits for the installed device type. Row bits above that width are stored as zero and take no part in the comparison. All notifications of a cycle take effect before that cycle's request is judged. A request therefore sees a row opened or closed in the same cycle.

Top module: `open_row_tracker`

## Requirements
- R1: A request whose bank record is valid and whose row equals the stored row (over the meaningful bits) yields decision code 2'b00 (hit).
- R2: A request whose bank record is valid but whose row differs from the stored row yields decision code 2'b01 (conflict).
- R3: A request whose bank record is not valid yields decision code 2'b10 (idle), whatever the row.
- R4: An activate report writes its row into the record chosen by its chip select and bank and marks that record valid; no other record changes.
- R5: A single-bank precharge report invalidates only the addressed record; the other banks of that chip select and the other chip select keep their open rows.
- R6: A precharge-all report or a refresh report invalidates all four records of the named chip select and leaves the other chip select untouched.
- R7: While reset is low, dec_vld is 0. After reset, all eight records are invalid.
- R8: cfg_row_bits gives the number of meaningful low row bits. A value of 0 or 14 or more means all 14 bits. Higher bits are stored as zero and are ignored in the comparison.
- R9: dec_vld is high for exactly the one cycle after each cycle with req_vld high. dec_code is then one of 2'b00, 2'b01 or 2'b10 and never 2'b11.
- R10: A request is judged against the record state after that cycle's reports. A same-cycle activate to its record gives hit or conflict against the new row. A same-cycle precharge or refresh of its record gives idle.
- R11: When an activate and a clearing report (precharge, precharge-all or refresh) hit the same record in one cycle, the activate wins and the record ends up valid with the new row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_row_bits | input | 4 | Number of meaningful row bits (0 or >=14 means 14) |
| req_vld | input | 1 | Access request strobe |
| req_cs | input | 1 | Request chip select |
| req_bank | input | 2 | Request bank |
| req_row | input | 14 | Request row |
| act_vld | input | 1 | Activate command report |
| act_cs | input | 1 | Activate chip select |
| act_bank | input | 2 | Activate bank |
| act_row | input | 14 | Row opened by the activate |
| pre_vld | input | 1 | Precharge command report |
| pre_all | input | 1 | Precharge covers all banks of pre_cs |
| pre_cs | input | 1 | Precharge chip select |
| pre_bank | input | 2 | Precharge bank (single-bank case) |
| ref_vld | input | 1 | Refresh command report |
| ref_cs | input | 1 | Refresh chip select |
| dec_vld | output | 1 | Decision valid, one cycle after req_vld |
| dec_code | output | 2 | 00 hit, 01 conflict, 10 idle |

## Verification
Two things can land in the same cycle: a bookkeeping update from an activate, precharge or refresh report, and a request that looks up the same record. The stimulus table sets a report and a request in one vector, both aimed at one chip select and bank. The decision is then checked against the state after the update: hit or conflict against the new row, or idle after a clear. A second collision is also driven and judged by a follow-up request: an activate and a clearing report on the same record, where the activate must win. Reset in the middle of a run is covered by directed steps after the table.

// File: rtl/ort_pkg.sv
// Package: shared sizes and the decision encoding of the open-row tracker.
// Assumes NUM_BANKS and NUM_CS are powers of two, so an entry index is {cs, bank}.
package ort_pkg;

    localparam int unsigned ORT_NUM_CS    = 2;
    localparam int unsigned ORT_NUM_BANKS = 4;
    localparam int unsigned ORT_ROW_W     = 14;

    // Decision codes returned one cycle after a request.
    typedef enum logic [1:0] {
        DEC_HIT      = 2'b00,
        DEC_CONFLICT = 2'b01,
        DEC_IDLE     = 2'b10
    } dec_code_e;

endpackage

// File: rtl/ort_row_mask.sv
// Module: turns the shared row-width setting into a mask of meaningful row bits.
// Assumes: a setting of 0 or of ROW_W or more selects the full ROW_W bits.
module ort_row_mask #(
    parameter int unsigned ROW_W = 14,
    localparam int unsigned RB_W = $clog2(ROW_W + 1)
) (
    input  logic [RB_W-1:0]  cfg_row_bits,
    output logic [ROW_W-1:0] row_mask
);

    logic [RB_W-1:0] eff_bits;

    // Clamp the setting to a usable width.
    always_comb begin
        if (cfg_row_bits == '0 || cfg_row_bits >= RB_W'(ROW_W)) begin
            eff_bits = RB_W'(ROW_W);
        end else begin
            eff_bits = cfg_row_bits;
        end
    end

    // One mask bit per row bit, set when the bit lies below the effective width.
    for (genvar i = 0; i < int'(ROW_W); i++) begin : g_bit
        assign row_mask[i] = (eff_bits > RB_W'(i));
    end

endmodule

// File: rtl/ort_notify_decode.sv
// Module: decodes activate, precharge and refresh reports into per-entry set and clear strobes.
// Assumes: the entry index is cs * NUM_BANKS + bank; the entry handles set-over-clear priority.
module ort_notify_decode #(
    parameter int unsigned NUM_CS    = 2,
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned N_ENT    = NUM_CS * NUM_BANKS
) (
    input  logic              act_vld,
    input  logic [CS_W-1:0]   act_cs,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              pre_vld,
    input  logic              pre_all,
    input  logic [CS_W-1:0]   pre_cs,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              ref_vld,
    input  logic [CS_W-1:0]   ref_cs,
    output logic [N_ENT-1:0]  ent_set,
    output logic [N_ENT-1:0]  ent_clr
);

    for (genvar e = 0; e < int'(N_ENT); e++) begin : g_ent
        localparam logic [CS_W-1:0]   E_CS   = CS_W'(e / int'(NUM_BANKS));
        localparam logic [BANK_W-1:0] E_BANK = BANK_W'(e % int'(NUM_BANKS));

        logic pre_hit;
        logic ref_hit;

        // Set strobe: an activate addressed to this entry.
        assign ent_set[e] = act_vld && (act_cs == E_CS) && (act_bank == E_BANK);

        // Precharge reaches this entry by bank match or through the all-banks flag.
        assign pre_hit = pre_vld && (pre_cs == E_CS) && (pre_all || (pre_bank == E_BANK));

        // Refresh closes every bank of its chip select.
        assign ref_hit = ref_vld && (ref_cs == E_CS);

        // Clear strobe: any closing report for this entry.
        assign ent_clr[e] = pre_hit || ref_hit;
    end

endmodule

// File: rtl/ort_bank_entry.sv
// Module: one tracking record (valid flag and row tag) for a single bank of a chip select.
// Assumes: set has priority over clear; the written row is masked so unused bits hold zero.
// The next-state values are exported so a same-cycle lookup sees the updated record.
module ort_bank_entry #(
    parameter int unsigned ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] row_mask,
    output logic             valid_nxt,
    output logic [ROW_W-1:0] tag_nxt
);

    logic             valid_q;
    logic [ROW_W-1:0] tag_q;

    // Next state: an activate opens the row, otherwise a close report drops the flag.
    always_comb begin
        valid_nxt = valid_q;
        tag_nxt   = tag_q;
        if (set_i) begin
            valid_nxt = 1'b1;
            tag_nxt   = set_row & row_mask;
        end else if (clr_i) begin
            valid_nxt = 1'b0;
        end
    end

    // Record register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else begin
            valid_q <= valid_nxt;
            tag_q   <= tag_nxt;
        end
    end

endmodule

// File: rtl/ort_decide.sv
// Module: looks up the addressed record, compares rows under the mask and registers the decision.
// Assumes: the record inputs are next-state values (write-first); index is {cs, bank}.
module ort_decide
    import ort_pkg::*;
#(
    parameter int unsigned NUM_CS    = 2,
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned ROW_W     = 14,
    localparam int unsigned CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned N_ENT    = NUM_CS * NUM_BANKS,
    localparam int unsigned IDX_W    = CS_W + BANK_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_vld,
    input  logic [CS_W-1:0]             req_cs,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic [ROW_W-1:0]            req_row,
    input  logic [ROW_W-1:0]            row_mask,
    input  logic [N_ENT-1:0]            ent_valid,
    input  logic [N_ENT-1:0][ROW_W-1:0] ent_tag,
    output logic                        dec_vld,
    output logic [1:0]                  dec_code
);

    logic [IDX_W-1:0] idx;
    logic             sel_valid;
    logic [ROW_W-1:0] sel_tag;
    logic             row_match;
    dec_code_e        code_nxt;

    // Entry index formed from chip select and bank.
    assign idx = {req_cs, req_bank};

    // Select the addressed record.
    always_comb begin
        sel_valid = 1'b0;
        sel_tag   = '0;
        for (int e = 0; e < int'(N_ENT); e++) begin
            if (idx == IDX_W'(e)) begin
                sel_valid = ent_valid[e];
                sel_tag   = ent_tag[e];
            end
        end
    end

    // Row comparison restricted to meaningful bits.
    assign row_match = (((sel_tag ^ req_row) & row_mask) == '0);

    // Classify the access into one of three command sequences.
    always_comb begin
        if (!sel_valid) begin
            code_nxt = DEC_IDLE;
        end else if (row_match) begin
            code_nxt = DEC_HIT;
        end else begin
            code_nxt = DEC_CONFLICT;
        end
    end

    // Decision register: one-cycle strobe and the code it qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld  <= 1'b0;
            dec_code <= DEC_IDLE;
        end else begin
            dec_vld <= req_vld;
            if (req_vld) begin
                dec_code <= code_nxt;
            end
        end
    end

endmodule

// File: rtl/open_row_tracker.sv
// Module: top of the per-bank open-row tracker for two chip selects of four banks each.
// Assumes: all reports of a cycle are applied before that cycle's request is judged;
// both chip selects share the row-width setting.
module open_row_tracker
    import ort_pkg::*;
#(
    parameter int unsigned NUM_CS    = ORT_NUM_CS,
    parameter int unsigned NUM_BANKS = ORT_NUM_BANKS,
    parameter int unsigned ROW_W     = ORT_ROW_W,
    localparam int unsigned CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned RB_W     = $clog2(ROW_W + 1),
    localparam int unsigned N_ENT    = NUM_CS * NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RB_W-1:0]   cfg_row_bits,
    input  logic              req_vld,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              act_vld,
    input  logic [CS_W-1:0]   act_cs,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              pre_vld,
    input  logic              pre_all,
    input  logic [CS_W-1:0]   pre_cs,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              ref_vld,
    input  logic [CS_W-1:0]   ref_cs,
    output logic              dec_vld,
    output logic [1:0]        dec_code
);

    logic [ROW_W-1:0]            row_mask;
    logic [N_ENT-1:0]            ent_set;
    logic [N_ENT-1:0]            ent_clr;
    logic [N_ENT-1:0]            ent_valid;
    logic [N_ENT-1:0][ROW_W-1:0] ent_tag;

    // Shared row-width mask.
    ort_row_mask #(
        .ROW_W (ROW_W)
    ) u_mask (
        .cfg_row_bits (cfg_row_bits),
        .row_mask     (row_mask)
    );

    // Report decoder.
    ort_notify_decode #(
        .NUM_CS    (NUM_CS),
        .NUM_BANKS (NUM_BANKS)
    ) u_notify (
        .act_vld  (act_vld),
        .act_cs   (act_cs),
        .act_bank (act_bank),
        .pre_vld  (pre_vld),
        .pre_all  (pre_all),
        .pre_cs   (pre_cs),
        .pre_bank (pre_bank),
        .ref_vld  (ref_vld),
        .ref_cs   (ref_cs),
        .ent_set  (ent_set),
        .ent_clr  (ent_clr)
    );

    // One record per chip-select/bank pair.
    for (genvar e = 0; e < int'(N_ENT); e++) begin : g_entry
        ort_bank_entry #(
            .ROW_W (ROW_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (ent_set[e]),
            .clr_i     (ent_clr[e]),
            .set_row   (act_row),
            .row_mask  (row_mask),
            .valid_nxt (ent_valid[e]),
            .tag_nxt   (ent_tag[e])
        );
    end

    // Lookup, compare and decision register.
    ort_decide #(
        .NUM_CS    (NUM_CS),
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .req_cs    (req_cs),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .row_mask  (row_mask),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .dec_vld   (dec_vld),
        .dec_code  (dec_code)
    );

endmodule

// File: rtl/ort_checker.sv
// Module: port-level properties of the open-row tracker, attached by bind.
// Assumes: the top module's default parameters.
module ort_checker #(
    parameter int unsigned CS_W   = 1,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ROW_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [CS_W-1:0]   req_cs,
    input logic [BANK_W-1:0] req_bank,
    input logic [ROW_W-1:0]  req_row,
    input logic              act_vld,
    input logic [CS_W-1:0]   act_cs,
    input logic [BANK_W-1:0] act_bank,
    input logic [ROW_W-1:0]  act_row,
    input logic              pre_vld,
    input logic              ref_vld,
    input logic [CS_W-1:0]   ref_cs,
    input logic              dec_vld,
    input logic [1:0]        dec_code
);

    AST_DEC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dec_vld == $past(req_vld))); // R9

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> (dec_code != 2'b11)); // R9

    AST_HIT_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld ##1 (req_vld && !act_vld && !pre_vld && !ref_vld
                     && req_cs == $past(act_cs) && req_bank == $past(act_bank)
                     && req_row == $past(act_row))
        |=> (dec_code == 2'b00)); // R1

    AST_BYPASS_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld && req_vld && act_cs == req_cs && act_bank == req_bank)
        |=> (dec_vld && dec_code != 2'b10)); // R10

    AST_IDLE_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_vld && !act_vld) ##1 (req_vld && !act_vld && req_cs == $past(ref_cs))
        |=> (dec_code == 2'b10)); // R6

endmodule

bind open_row_tracker ort_checker #(
    .CS_W   (CS_W),
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_cs   (req_cs),
    .req_bank (req_bank),
    .req_row  (req_row),
    .act_vld  (act_vld),
    .act_cs   (act_cs),
    .act_bank (act_bank),
    .act_row  (act_row),
    .pre_vld  (pre_vld),
    .ref_vld  (ref_vld),
    .ref_cs   (ref_cs),
    .dec_vld  (dec_vld),
    .dec_code (dec_code)
);

// File: tb/sim_open_row_tracker.sv
// Bench: table-driven stimulus for the open-row tracker, then directed reset steps.
module sim_open_row_tracker;

    localparam logic [1:0] E_HIT  = 2'b00;
    localparam logic [1:0] E_CONF = 2'b01;
    localparam logic [1:0] E_IDLE = 2'b10;
    localparam logic [1:0] E_NONE = 2'b11;   // no decision expected

    typedef struct packed {
        logic        act;
        logic        acs;
        logic [1:0]  abank;
        logic [13:0] arow;
        logic        pre;
        logic        pall;
        logic        pcs;
        logic [1:0]  pbank;
        logic        rf;
        logic        rfcs;
        logic        rq;
        logic        qcs;
        logic [1:0]  qbank;
        logic [13:0] qrow;
        logic [3:0]  rbits;
        logic [1:0]  exp;
        logic [3:0]  rid;
    } vec_t;

    localparam int NV = 26;
    // act acs ab arow | pre pall pcs pb | rf rfcs | rq qcs qb qrow | rbits exp rid
    localparam vec_t VECS [NV] = '{
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,0,0,14'h0005, 4'd14, E_IDLE, 4'd7},  // R7 nothing open
        '{1,0,0,14'h0123, 0,0,0,0, 0,0, 0,0,0,14'h0000, 4'd14, E_NONE, 4'd4},  // R4 open
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,0,0,14'h0123, 4'd14, E_HIT,  4'd1},  // R1
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,0,0,14'h0124, 4'd14, E_CONF, 4'd2},  // R2
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,1,0,14'h0123, 4'd14, E_IDLE, 4'd3},  // R3 other cs
        '{1,1,2,14'h3FFF, 0,0,0,0, 0,0, 0,0,0,14'h0000, 4'd14, E_NONE, 4'd4},  // R4
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,1,2,14'h3FFF, 4'd14, E_HIT,  4'd4},  // R4 full row
        '{0,0,0,14'h0000, 1,0,0,0, 0,0, 0,0,0,14'h0000, 4'd14, E_NONE, 4'd5},  // R5 precharge
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,0,0,14'h0123, 4'd14, E_IDLE, 4'd5},  // R5
        '{1,0,1,14'h00AA, 0,0,0,0, 0,0, 0,0,0,14'h0000, 4'd14, E_NONE, 4'd4},  // R4
        '{1,0,3,14'h0055, 0,0,0,0, 0,0, 0,0,0,14'h0000, 4'd14, E_NONE, 4'd4},  // R4
        '{0,0,0,14'h0000, 1,0,0,3, 0,0, 1,0,1,14'h00AA, 4'd14, E_HIT,  4'd5},  // R5 b3 closed, b1 kept
        '{0,0,0,14'h0000, 0,0,0,0, 1,0, 0,0,0,14'h0000, 4'd14, E_NONE, 4'd6},  // R6 refresh cs0
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,0,1,14'h00AA, 4'd14, E_IDLE, 4'd6},  // R6
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,1,2,14'h3FFF, 4'd14, E_HIT,  4'd6},  // R6 cs1 untouched
        '{1,0,2,14'h2001, 0,0,0,0, 0,0, 0,0,0,14'h0000, 4'd13, E_NONE, 4'd8},  // R8 bit13 dropped
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,0,2,14'h0001, 4'd13, E_HIT,  4'd8},  // R8
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,0,2,14'h1001, 4'd13, E_CONF, 4'd8},  // R8 bit12 counts
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,0,2,14'h3001, 4'd12, E_HIT,  4'd8},  // R8 bit12 ignored
        '{1,1,1,14'h0777, 0,0,0,0, 0,0, 1,1,1,14'h0777, 4'd0,  E_HIT,  4'd10}, // R10 act bypass hit
        '{1,1,3,14'h0010, 0,0,0,0, 0,0, 1,1,3,14'h0011, 4'd0,  E_CONF, 4'd10}, // R10 act bypass conflict
        '{0,0,0,14'h0000, 1,0,1,2, 0,0, 1,1,2,14'h3FFF, 4'd14, E_IDLE, 4'd10}, // R10 precharge bypass
        '{1,1,0,14'h0044, 1,1,1,0, 0,0, 0,0,0,14'h0000, 4'd14, E_NONE, 4'd11}, // R11 all + act
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,1,0,14'h0044, 4'd14, E_HIT,  4'd11}, // R11
        '{0,0,0,14'h0000, 0,0,0,0, 0,0, 1,1,1,14'h0777, 4'd14, E_IDLE, 4'd6},  // R6 precharge-all
        '{1,1,0,14'h0045, 0,0,0,0, 1,1, 1,1,0,14'h0045, 4'd14, E_HIT,  4'd11}  // R11 refresh + act
    };

    logic        clk;
    logic        rst_n;
    logic [3:0]  cfg_row_bits;
    logic        req_vld;
    logic        req_cs;
    logic [1:0]  req_bank;
    logic [13:0] req_row;
    logic        act_vld;
    logic        act_cs;
    logic [1:0]  act_bank;
    logic [13:0] act_row;
    logic        pre_vld;
    logic        pre_all;
    logic        pre_cs;
    logic [1:0]  pre_bank;
    logic        ref_vld;
    logic        ref_cs;
    logic        dec_vld;
    logic [1:0]  dec_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    open_row_tracker u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_row_bits (cfg_row_bits),
        .req_vld      (req_vld),
        .req_cs       (req_cs),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .act_vld      (act_vld),
        .act_cs       (act_cs),
        .act_bank     (act_bank),
        .act_row      (act_row),
        .pre_vld      (pre_vld),
        .pre_all      (pre_all),
        .pre_cs       (pre_cs),
        .pre_bank     (pre_bank),
        .ref_vld      (ref_vld),
        .ref_cs       (ref_cs),
        .dec_vld      (dec_vld),
        .dec_code     (dec_code)
    );

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic drive(input vec_t v);
        act_vld = v.act;  act_cs = v.acs;  act_bank = v.abank; act_row = v.arow;
        pre_vld = v.pre;  pre_all = v.pall; pre_cs = v.pcs;   pre_bank = v.pbank;
        ref_vld = v.rf;   ref_cs = v.rfcs;
        req_vld = v.rq;   req_cs = v.qcs;  req_bank = v.qbank; req_row = v.qrow;
        cfg_row_bits = v.rbits;
    endtask

    task automatic quiet();
        drive('{0,0,0,14'h0,0,0,0,0,0,0,0,0,0,14'h0,4'd14,E_NONE,4'd0});
    endtask

    // Compare the outputs sampled at a falling edge against expectation.
    task automatic check(input logic [1:0] exp, input int rid);
        n_tests++;
        if (exp == E_NONE) begin
            if (dec_vld !== 1'b0) begin
                n_fail++;
                $display("FAIL R%0d: dec_vld=%b expected 0", rid, dec_vld);
            end
        end else if (dec_vld !== 1'b1 || dec_code !== exp) begin
            n_fail++;
            $display("FAIL R%0d: dec_vld=%b dec_code=%b expected 1/%b", rid, dec_vld, dec_code, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        quiet();
        req_vld = 1'b1;               // request during reset must not produce a decision
        repeat (3) @(negedge clk);
        check(E_NONE, 7);             // R7 no decision while in reset
        rst_n = 1'b1;
        quiet();
        @(negedge clk);
        check(E_NONE, 7);             // R7 quiet after reset

        // Table walk: drive at a falling edge, check at the next falling edge.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check(VECS[i].exp, int'(VECS[i].rid));
        end
        quiet();
        @(negedge clk);
        check(E_NONE, 9);             // R9 strobe lasts one cycle only

        // Directed: back-to-back requests give back-to-back decisions (R9).
        drive('{0,0,0,14'h0,0,0,0,0,0,0,1,1,0,14'h0045,4'd14,E_HIT,4'd9});
        @(negedge clk);
        check(E_HIT, 9);
        drive('{0,0,0,14'h0,0,0,0,0,0,0,1,1,0,14'h0046,4'd14,E_CONF,4'd9});
        @(negedge clk);
        check(E_CONF, 9);

        // Directed: reset mid-run wipes all open rows (R7).
        quiet();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive('{0,0,0,14'h0,0,0,0,0,0,0,1,1,0,14'h0045,4'd14,E_IDLE,4'd7});
        @(negedge clk);
        check(E_IDLE, 7);             // R7 cs1 bank0 was open before reset
        drive('{0,0,0,14'h0,0,0,0,0,0,0,1,0,2,14'h0001,4'd14,E_IDLE,4'd7});
        @(negedge clk);
        check(E_IDLE, 7);             // R7 cs0 bank2 was open before reset
        quiet();
        @(negedge clk);
        finish_run();
    end

endmodule